// File: doc/BRIEF.md
# Byte-Serial Register Pair Adder

This block adds one 16-bit register pair into another using a single byte-wide add-with-carry unit, which is reused for each byte lane in turn. It holds six 16-bit pairs, named HL, IX, IY, BC, DE and SP. A command names a destination pair, which must be HL, IX or IY, and a source pair, which may be any of the six. The block latches one byte of each operand into an accumulator latch and a summand latch and adds them. It writes the sum back into the destination's byte lane, then moves to the next lane. A carry flip-flop links the low pass to the high pass. The carry out of the top byte is given as a flag when the operation finishes.

Commands arrive on a valid/ready channel. `cmd_ready` is high only while the block is idle. A command is taken at a rising clock edge where both `cmd_valid` and `cmd_ready` are high, and its fields may change freely after that edge. A sender may raise `cmd_valid` before ready is high and may hold it high while the block is busy; nothing is taken until ready returns.

A plain host port loads any pair while the block is idle. A combinational read port shows any pair at any time.

Top module: `pair_adder16`

## Requirements
- R1: After reset, all six pairs read 0x0000, `cmd_ready` is 1, and `done` and `carry_flag` are 0.
- R2: Pair codes are 0=HL, 1=IX, 2=IY, 3=BC, 4=DE, 5=SP. While the block is idle, `hw_en` with `hw_sel` 0..5 stores `hw_data` into that pair at the rising edge. `rd_data` shows the new value from the next cycle.
- R3: After a command is accepted, `cmd_ready` is low for seven cycles. `done` is high for exactly one cycle, starting at the 7th rising edge after acceptance, and `cmd_ready` is high again in that same cycle.
- R4: When `done` is high, the destination holds (destination + source) mod 2^16. When the two pairs differ, the source is unchanged.
- R5: In the `done` cycle, `carry_flag` equals the carry out of bit 15. It keeps that value until the next legal command has been accepted.
- R6: The carry out of the low byte feeds the high-byte addition (0x00FF + 0x0001 gives 0x0100). The carry is cleared at the start of every operation, so a previous carry never enters a new sum.
- R7: When the destination and the source are the same pair, both operands are its value from before the operation, and the result is twice that value mod 2^16.
- R8: The low byte of the destination is rewritten at the 3rd rising edge after acceptance, and the high byte at the 7th. Between those edges, the destination reads {old high byte, new low byte}.
- R9: A host write (`hw_en`) presented while the block is busy is ignored.
- R10: A host write presented in the same cycle that a command is accepted takes effect before the operands are loaded. The operation then uses the newly written value.
- R11: A command whose destination code is 3..7, or whose source code is 6..7, is accepted and dropped. No pair changes, `done` stays low, and `cmd_ready` stays high.
- R12: Changes to `cmd_dst`, `cmd_src` or `cmd_valid` while the block is busy do not affect the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_dst | input | 3 | Destination pair code (0..2 legal) |
| cmd_src | input | 3 | Source pair code (0..5 legal) |
| done | output | 1 | One-cycle pulse when a sum has been written |
| carry_flag | output | 1 | Carry out of bit 15 of the last sum |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 3 | Host write pair code |
| hw_data | input | 16 | Host write value |
| rd_sel | input | 3 | Read port pair code |
| rd_data | output | 16 | Value of the selected pair (0 for codes 6, 7) |

## Verification
A host write can land in the same cycle that a command is accepted. It can also land in a cycle while the block is busy. The bench provokes the first case by raising `hw_en` on the source pair together with `cmd_valid`, and expects a sum built from the new value. It provokes the second case by writing during the low-byte pass, and expects the source to be untouched and the sum to use the old value. A near-exhaustive sweep covers every destination/source pairing over a set of carry-boundary values, including same-pair operations, and checks the half-written destination in the middle of each run.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int unsigned NUM_PAIRS = 6;
  localparam int unsigned NUM_DST   = 3;
  localparam int unsigned SEL_W     = 3;

  typedef enum logic [2:0] {
    PR_HL = 3'd0,
    PR_IX = 3'd1,
    PR_IY = 3'd2,
    PR_BC = 3'd3,
    PR_DE = 3'd4,
    PR_SP = 3'd5
  } pair_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADD,
    ST_STORE,
    ST_SEL
  } state_e;
endpackage

// File: rtl/pa_adc.sv
module pa_adc #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
  end
endmodule

// File: rtl/pa_regfile.sv
module pa_regfile
  import pa_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  localparam int WORD_W   = LANE_W * NUM_LANES,
  localparam int LANE_IW  = $clog2(NUM_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [SEL_W-1:0]   host_sel,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [LANE_IW-1:0] lane,
  input  logic [SEL_W-1:0]   a_sel,
  input  logic [SEL_W-1:0]   b_sel,
  output logic [LANE_W-1:0]  a_byte,
  output logic [LANE_W-1:0]  b_byte,
  input  logic               byte_we,
  input  logic [SEL_W-1:0]   byte_sel,
  input  logic [LANE_W-1:0]  byte_wdata
);
  logic [WORD_W-1:0] pairs_q [NUM_PAIRS];
  int lane_base;

  always_comb begin
    lane_base = int'(lane) * LANE_W;
    a_byte  = '0;
    b_byte  = '0;
    rd_data = '0;
    if (a_sel < SEL_W'(NUM_PAIRS))  a_byte  = pairs_q[a_sel][lane_base +: LANE_W];
    if (b_sel < SEL_W'(NUM_PAIRS))  b_byte  = pairs_q[b_sel][lane_base +: LANE_W];
    if (rd_sel < SEL_W'(NUM_PAIRS)) rd_data = pairs_q[rd_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAIRS; p++) pairs_q[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (host_we && host_sel == SEL_W'(p))
          pairs_q[p] <= host_wdata;
        else if (byte_we && byte_sel == SEL_W'(p))
          pairs_q[p][lane_base +: LANE_W] <= byte_wdata;
      end
    end
  end

  // R9: the host port and the byte store come from separate logic and never coincide
  a_r9_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && byte_we));

  // R2: a host write is visible in the addressed pair one cycle later
  a_r2_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel < SEL_W'(NUM_PAIRS)) |=>
      (pairs_q[$past(host_sel)] == $past(host_wdata)));
endmodule

// File: rtl/pa_seq.sv
module pa_seq
  import pa_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  localparam int LANE_IW  = $clog2(NUM_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [SEL_W-1:0]   cmd_dst,
  input  logic [SEL_W-1:0]   cmd_src,
  input  logic [LANE_W-1:0]  a_byte,
  input  logic [LANE_W-1:0]  b_byte,
  output logic [LANE_IW-1:0] lane,
  output logic [SEL_W-1:0]   dst_sel,
  output logic [SEL_W-1:0]   src_sel,
  output logic               byte_we,
  output logic [LANE_W-1:0]  byte_wdata,
  output logic               done,
  output logic               carry_flag
);
  localparam logic [LANE_IW-1:0] LAST_LANE = LANE_IW'(NUM_LANES - 1);

  state_e             state_q;
  logic [LANE_IW-1:0] lane_q;
  logic [SEL_W-1:0]   dst_q, src_q;
  logic [LANE_W-1:0]  acc_q, smd_q;
  logic               carry_q, done_q;
  logic [LANE_W-1:0]  sum;
  logic               cout;
  logic               legal;

  pa_adc #(.W(LANE_W)) adc_i (
    .a(acc_q), .b(smd_q), .cin(carry_q), .sum(sum), .cout(cout)
  );

  assign legal      = (cmd_dst < SEL_W'(NUM_DST)) && (cmd_src < SEL_W'(NUM_PAIRS));
  assign cmd_ready  = (state_q == ST_IDLE);
  assign lane       = lane_q;
  assign dst_sel    = dst_q;
  assign src_sel    = src_q;
  assign byte_we    = (state_q == ST_STORE);
  assign byte_wdata = acc_q;
  assign done       = done_q;
  assign carry_flag = carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      dst_q   <= '0;
      src_q   <= '0;
      acc_q   <= '0;
      smd_q   <= '0;
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid && legal) begin
            dst_q   <= cmd_dst;
            src_q   <= cmd_src;
            lane_q  <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          acc_q <= a_byte;
          smd_q <= b_byte;
          if (lane_q == '0) carry_q <= 1'b0;
          state_q <= ST_ADD;
        end
        ST_ADD: begin
          acc_q   <= sum;
          carry_q <= cout;
          state_q <= ST_STORE;
        end
        ST_STORE: begin
          if (lane_q == LAST_LANE) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SEL;
          end
        end
        ST_SEL: begin
          lane_q  <= lane_q + 1'b1;
          state_q <= ST_LOAD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a legal accepted command starts the first lane load
  a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && legal) |=> (state_q == ST_LOAD && lane_q == '0));

  // R3: done lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: the carry is clear before the first lane is added
  a_r6_carry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && lane_q == '0) |=> !carry_q);

  // R11: an illegal command leaves the block idle with no done
  a_r11_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !legal) |=> (state_q == ST_IDLE && !done_q));

  // R12: the captured pair codes hold while busy
  a_r12_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> ($stable(dst_q) && $stable(src_q)));
endmodule

// File: rtl/pair_adder16.sv
module pair_adder16
  import pa_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  localparam int WORD_W   = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_dst,
  input  logic [2:0]        cmd_src,
  output logic              done,
  output logic              carry_flag,
  input  logic              hw_en,
  input  logic [2:0]        hw_sel,
  input  logic [WORD_W-1:0] hw_data,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data
);
  localparam int LANE_IW = $clog2(NUM_LANES);

  logic [LANE_IW-1:0] lane;
  logic [SEL_W-1:0]   dst_sel, src_sel;
  logic [LANE_W-1:0]  a_byte, b_byte, byte_wdata;
  logic               byte_we;
  logic               host_we;

  assign host_we = hw_en && cmd_ready;

  pa_seq #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dst(cmd_dst), .cmd_src(cmd_src),
    .a_byte(a_byte), .b_byte(b_byte),
    .lane(lane), .dst_sel(dst_sel), .src_sel(src_sel),
    .byte_we(byte_we), .byte_wdata(byte_wdata),
    .done(done), .carry_flag(carry_flag)
  );

  pa_regfile #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(hw_sel), .host_wdata(hw_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .lane(lane), .a_sel(dst_sel), .b_sel(src_sel),
    .a_byte(a_byte), .b_byte(b_byte),
    .byte_we(byte_we), .byte_sel(dst_sel), .byte_wdata(byte_wdata)
  );

  // R9: a host strobe while busy must not reach the pair file
  a_r9_busy_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !cmd_ready) |-> !host_we);
endmodule

// File: tb/pair_adder16_tb_top.sv
module pair_adder16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_dst = '0;
  logic [2:0]  cmd_src = '0;
  logic        done;
  logic        carry_flag;
  logic        hw_en = 1'b0;
  logic [2:0]  hw_sel = '0;
  logic [15:0] hw_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pair_adder16 dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dst(cmd_dst), .cmd_src(cmd_src),
    .done(done), .carry_flag(carry_flag),
    .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h00FF;
      3: return 16'h0100;
      4: return 16'h7FFF;
      5: return 16'h8000;
      6: return 16'hFFFF;
      default: return 16'hA5C3;
    endcase
  endfunction

  task automatic hwrite(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = sel; hw_data = data;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic rdpair(input logic [2:0] sel, output logic [15:0] data);
    rd_sel = sel;
    #1;
    data = rd_data;
  endtask

  // mode 0 plain, 1 host write while busy, 2 host write with accept, 3 field churn while busy
  task automatic run_op(input logic [2:0] d, input logic [2:0] s, input int mode,
                        input logic [15:0] wval, output int lat,
                        output logic [15:0] mid, output bit busy_ok);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dst = d; cmd_src = s;
    if (mode == 2) begin hw_en = 1'b1; hw_sel = s; hw_data = wval; end
    @(negedge clk);
    cmd_valid = 1'b0; hw_en = 1'b0;
    rd_sel = d;
    #1;
    lat = 1; busy_ok = 1'b1; mid = '0;
    while (!done && lat < 20) begin
      if (cmd_ready) busy_ok = 1'b0;
      if (lat == 2 && mode == 1) begin hw_en = 1'b1; hw_sel = s; hw_data = wval; end
      if (lat == 2 && mode == 3) begin cmd_dst = 3'd1; cmd_src = 3'd5; end
      if (lat == 3) hw_en = 1'b0;
      if (lat == 5) mid = rd_data;
      @(negedge clk);
      #1;
      lat++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, a, b, exp, mid;
    logic        cexp;
    int          lat;
    bit          bok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int p = 0; p < 6; p++) begin
      rdpair(3'(p), v);
      check(v == 16'h0000, "R1 pair reset", 32'(v), 32'h0);
    end
    check(cmd_ready && !done && !carry_flag, "R1 control reset",
          {29'd0, cmd_ready, done, carry_flag}, 32'h4);

    // R2 host write / readback on every pair
    for (int p = 0; p < 6; p++) hwrite(3'(p), 16'h1111 * 16'(p + 1));
    for (int p = 0; p < 6; p++) begin
      rdpair(3'(p), v);
      check(v == 16'h1111 * 16'(p + 1), "R2 host write", 32'(v), 32'(16'h1111 * 16'(p + 1)));
    end

    // R6 carry chain from low to high byte
    hwrite(3'd0, 16'h00FF); hwrite(3'd3, 16'h0001);
    run_op(3'd0, 3'd3, 0, '0, lat, mid, bok);
    rdpair(3'd0, v);
    check(v == 16'h0100, "R6 low carry into high", 32'(v), 32'h0100);
    // R6 stale carry must not enter next sum
    hwrite(3'd1, 16'hFFFF); hwrite(3'd4, 16'h0001);
    run_op(3'd1, 3'd4, 0, '0, lat, mid, bok);
    check(carry_flag == 1'b1, "R5 carry out set", 32'(carry_flag), 32'h1);
    hwrite(3'd2, 16'h0000); hwrite(3'd5, 16'h0000);
    run_op(3'd2, 3'd5, 0, '0, lat, mid, bok);
    rdpair(3'd2, v);
    check(v == 16'h0000 && !carry_flag, "R6 carry cleared at start", {15'd0, carry_flag, v}, 32'h0);

    // R4 R5 R7 R8 R3 sweep over every pairing and value pair
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 6; s++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            hwrite(3'(d), val(i));
            hwrite(3'(s), val(j));
            a = (d == s) ? val(j) : val(i);
            b = val(j);
            {cexp, exp} = {1'b0, a} + {1'b0, b};
            run_op(3'(d), 3'(s), 0, '0, lat, mid, bok);
            check(lat == 8 && bok, "R3 latency/ready", 32'(lat), 32'd8);
            check(mid == {a[15:8], exp[7:0]}, "R8 half written", 32'(mid), 32'({a[15:8], exp[7:0]}));
            rdpair(3'(d), v);
            check(v == exp, (d == s) ? "R7 same pair" : "R4 sum", 32'(v), 32'(exp));
            check(carry_flag == cexp, "R5 carry flag", 32'(carry_flag), 32'(cexp));
            if (d != s) begin
              rdpair(3'(s), v);
              check(v == b, "R4 source kept", 32'(v), 32'(b));
            end
          end

    // R5 flag held after done
    @(negedge clk);
    check(carry_flag == cexp && !done, "R5 flag held", {30'd0, done, carry_flag}, 32'(cexp));

    // R9 host write while busy ignored
    hwrite(3'd0, 16'h1234); hwrite(3'd3, 16'h0101);
    run_op(3'd0, 3'd3, 1, 16'hDEAD, lat, mid, bok);
    rdpair(3'd0, v);
    check(v == 16'h1335, "R9 sum uses old source", 32'(v), 32'h1335);
    rdpair(3'd3, v);
    check(v == 16'h0101, "R9 busy write dropped", 32'(v), 32'h0101);

    // R10 host write in accept cycle is seen by the operation
    hwrite(3'd1, 16'h2000); hwrite(3'd4, 16'h0003);
    run_op(3'd1, 3'd4, 2, 16'h0F0F, lat, mid, bok);
    rdpair(3'd1, v);
    check(v == 16'h2F0F, "R10 accept-cycle write used", 32'(v), 32'h2F0F);
    rdpair(3'd4, v);
    check(v == 16'h0F0F, "R10 accept-cycle write stored", 32'(v), 32'h0F0F);

    // R12 field churn while busy
    hwrite(3'd2, 16'h0800); hwrite(3'd3, 16'h0080);
    hwrite(3'd1, 16'h5555);
    run_op(3'd2, 3'd3, 3, '0, lat, mid, bok);
    rdpair(3'd2, v);
    check(v == 16'h0880, "R12 churn result", 32'(v), 32'h0880);
    rdpair(3'd1, v);
    check(v == 16'h5555 && lat == 8, "R12 other pair untouched", 32'(v), 32'h5555);

    // R11 illegal codes dropped
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_dst = (k == 0) ? 3'd3 : 3'd0;
      cmd_src = (k == 0) ? 3'd0 : 3'd6;
      @(negedge clk);
      cmd_valid = 1'b0;
      bok = 1'b1;
      for (int c = 0; c < 10; c++) begin
        if (done || !cmd_ready) bok = 1'b0;
        @(negedge clk);
      end
      check(bok, "R11 no done, ready held", 32'(bok), 32'h1);
      rdpair(3'd0, v);
      check(v == 16'h1335, "R11 no pair change", 32'(v), 32'h1335);
      rdpair(3'd3, v);
      check(v == 16'h0080, "R11 no pair change", 32'(v), 32'h0080);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule